// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flag Update

This block is a purely combinational arithmetic-logic unit for a 16-bit datapath. It can also run at byte width. It takes two operands, an operation code, a width select and the current flag word. It returns the computed value, a strobe that says whether the value should be stored, and the new flag word. Each operation has its own rule for which of the six status flags it rewrites and which it keeps.

In byte mode only the low eight bits take part. The upper byte of the result is copied from operand A, so a store back to the same register leaves its upper half intact. All flags are then taken from the byte result. The carry from the previous operation is read from the C bit of the incoming flag word, and the carry-in for add-with-carry and subtract-with-borrow comes from there as well. Bits of the flag word that are not status flags go through unaltered.

Top module: `alu_flag_unit`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+C_in. Both rewrite all six status flags. C is the carry out of the top bit of the active width. O is signed overflow. S is the top bit of the active width. Z is set when the active-width result is zero.
- R2: Code 2 (subtract) gives A-B, code 3 (subtract with borrow) gives A-B-C_in, and code 4 (compare) computes A-B. All three rewrite all six status flags, and C is the borrow out of the top bit.
- R3: Code 4 (compare) and code 11 (test) drive the write strobe low. Every other defined code except the unused ones drives it high.
- R4: Code 5 (increment, A+1) and code 6 (decrement, A-1) rewrite O, S, Z, A and P, and leave C equal to the incoming C.
- R5: Code 7 (negate) gives 0-A. It sets C exactly when the active-width operand is nonzero, and it rewrites the other five status flags from the difference.
- R6: Codes 8, 9 and 10 (and, or, xor) and code 11 (test, a bitwise and) set S, Z and P from the result, and clear O, C and A.
- R7: Code 12 (not) inverts every active-width bit of A and leaves the flag word unchanged.
- R8: Status flags occupy fixed flag-word bits: C at 0, P at 2, A at 4, Z at 6, S at 7, O at 11.
- R9: P is 1 when the low byte of the result holds an even number of ones, in both widths.
- R10: The A flag is the carry out of bit 3 for additions, and the borrow out of bit 3 for subtractions.
- R11: Flag-word bits other than the six status flags pass through from the input unchanged for every code.
- R12: Width select 0 operates on bits 7:0 only. Result bits 15:8 then equal operand A bits 15:8, and C, O, S and Z are taken at byte width.
- R13: Codes 13 to 15 are unused. They drive the write strobe low and pass the flag word through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (destination side) |
| op_b | input | 16 | Second operand (source side) |
| op_code | input | 4 | Operation select, encodings as in R1 to R13 |
| wide | input | 1 | 1 = 16-bit operation, 0 = byte operation |
| flags_in | input | 16 | Current flag word, including the incoming carry |
| result | output | 16 | Computed value |
| result_we | output | 1 | High when the result should be stored |
| flags_out | output | 16 | Updated flag word |

## Verification
The block holds no state, so any fault in its decode, in the adder carry chain or in the flag merge shows at the ports in the same cycle as the stimulus. A wrong carry-in choice appears as a result off by one. A wrong borrow inversion flips C or A. A wrong update-policy decode shows as a kept flag that changed, or as a cleared flag that stayed set. The directed cases are chosen so that each flag sits at a value that differs from its incoming value, and so that every flag is driven to both 0 and 1 somewhere in the run.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_CMP  = 4'd4,
      OP_INC  = 4'd5,
      OP_DEC  = 4'd6,
      OP_NEG  = 4'd7,
      OP_AND  = 4'd8,
      OP_OR   = 4'd9,
      OP_XOR  = 4'd10,
      OP_TEST = 4'd11,
      OP_NOT  = 4'd12
   } alu_op_e;

   // how the status flags are rewritten
   typedef enum logic [1:0] {
      FK_NONE,
      FK_ARITH,
      FK_KEEPC,
      FK_LOGIC
   } flag_kind_e;

   typedef enum logic [1:0] {
      BW_AND,
      BW_OR,
      BW_XOR,
      BW_NOT
   } bw_sel_e;

   // status flag positions inside the flag word
   localparam int FB_C = 0;
   localparam int FB_P = 2;
   localparam int FB_A = 4;
   localparam int FB_Z = 6;
   localparam int FB_S = 7;
   localparam int FB_O = 11;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         cout,
   output logic         aux,
   output logic         ovf
);

   if (W < 4) begin : g_bad_w
      $error("alu_addsub: W must be at least 4");
   end

   logic [W-1:0] y_eff;
   logic         c0;
   logic [W:0]   full;
   logic [4:0]   nib;

   // subtraction as x + ~y + ~borrow, carries inverted back afterwards
   always_comb begin
      y_eff = sub ? ~y : y;
      c0    = sub ? ~cin : cin;
      full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c0};
      nib   = {1'b0, x[3:0]} + {1'b0, y_eff[3:0]} + {4'b0, c0};
      res   = full[W-1:0];
      cout  = full[W] ^ sub;
      aux   = nib[4] ^ sub;
      ovf   = (x[W-1] == y_eff[W-1]) && (full[W-1] != x[W-1]);
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_flag_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  bw_sel_e      sel,
   output logic [W-1:0] y
);

   always_comb begin
      unique case (sel)
         BW_AND:  y = a & b;
         BW_OR:   y = a | b;
         BW_XOR:  y = a ^ b;
         default: y = ~a;
      endcase
   end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int FLAG_W = 16
) (
   input  logic [DATA_W-1:0] res,
   input  logic              wide,
   input  logic              c_new,
   input  logic              a_new,
   input  logic              o_new,
   input  flag_kind_e        kind,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out
);

   localparam logic [FLAG_W-1:0] STAT_MASK =
      (FLAG_W'(1) << FB_C) | (FLAG_W'(1) << FB_P) | (FLAG_W'(1) << FB_A) |
      (FLAG_W'(1) << FB_Z) | (FLAG_W'(1) << FB_S) | (FLAG_W'(1) << FB_O);

   logic s_new, z_new, p_new;

   always_comb begin
      s_new = wide ? res[DATA_W-1] : res[BYTE_W-1];
      z_new = wide ? (res == '0) : (res[BYTE_W-1:0] == '0);
      p_new = ~^res[7:0];
      flags_out = flags_in;
      unique case (kind)
         FK_ARITH, FK_KEEPC: begin
            flags_out[FB_O] = o_new;
            flags_out[FB_S] = s_new;
            flags_out[FB_Z] = z_new;
            flags_out[FB_A] = a_new;
            flags_out[FB_P] = p_new;
            if (kind == FK_ARITH) flags_out[FB_C] = c_new;
         end
         FK_LOGIC: begin
            flags_out[FB_O] = 1'b0;
            flags_out[FB_S] = s_new;
            flags_out[FB_Z] = z_new;
            flags_out[FB_A] = 1'b0;
            flags_out[FB_P] = p_new;
            flags_out[FB_C] = 1'b0;
         end
         default: ;
      endcase
   end

   // checks on the merged word
   always_comb begin
      p_keep_other_r11: assert ((flags_out & ~STAT_MASK) == (flags_in & ~STAT_MASK))
         else $error("non-status flag bit altered");
      if (kind == FK_NONE) begin
         p_none_hold_r7: assert (flags_out == flags_in)
            else $error("flag word changed on no-update operation");
      end
      if (kind == FK_LOGIC) begin
         p_logic_clear_r6: assert (!flags_out[FB_O] && !flags_out[FB_C] && !flags_out[FB_A])
            else $error("logic op left O, C or A set");
      end
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int FLAG_W    = 16,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [3:0]        op_code,
   input  logic              wide,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0] result,
   output logic              result_we,
   output logic [FLAG_W-1:0] flags_out
);

   localparam int HI_W = DATA_W - BYTE_W;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   if (DATA_W <= BYTE_W) begin : g_chk_w
      $error("alu_flag_unit: DATA_W must exceed BYTE_W");
   end
   if (BYTE_W < 8) begin : g_chk_b
      $error("alu_flag_unit: BYTE_W must be at least 8 for parity");
   end
   if (FLAG_W <= FB_O) begin : g_chk_f
      $error("alu_flag_unit: FLAG_W too narrow for flag positions");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] ad_x, ad_y;
   logic              ad_cin, ad_sub, use_bw, we_d;
   bw_sel_e           bw_sel;
   flag_kind_e        kind;
   logic              wide_eff;

   assign op = alu_op_e'(op_code);

   // operation decode
   always_comb begin
      ad_x   = op_a;
      ad_y   = op_b;
      ad_cin = 1'b0;
      ad_sub = 1'b0;
      use_bw = 1'b0;
      bw_sel = BW_AND;
      kind   = FK_NONE;
      we_d   = 1'b0;
      case (op)
         OP_ADD:  begin kind = FK_ARITH; we_d = 1'b1; end
         OP_ADC:  begin kind = FK_ARITH; we_d = 1'b1; ad_cin = flags_in[FB_C]; end
         OP_SUB:  begin kind = FK_ARITH; we_d = 1'b1; ad_sub = 1'b1; end
         OP_SBB:  begin kind = FK_ARITH; we_d = 1'b1; ad_sub = 1'b1; ad_cin = flags_in[FB_C]; end
         OP_CMP:  begin kind = FK_ARITH; ad_sub = 1'b1; end
         OP_INC:  begin kind = FK_KEEPC; we_d = 1'b1; ad_y = ONE; end
         OP_DEC:  begin kind = FK_KEEPC; we_d = 1'b1; ad_y = ONE; ad_sub = 1'b1; end
         OP_NEG:  begin kind = FK_ARITH; we_d = 1'b1; ad_x = '0; ad_y = op_a; ad_sub = 1'b1; end
         OP_AND:  begin kind = FK_LOGIC; we_d = 1'b1; use_bw = 1'b1; bw_sel = BW_AND; end
         OP_OR:   begin kind = FK_LOGIC; we_d = 1'b1; use_bw = 1'b1; bw_sel = BW_OR; end
         OP_XOR:  begin kind = FK_LOGIC; we_d = 1'b1; use_bw = 1'b1; bw_sel = BW_XOR; end
         OP_TEST: begin kind = FK_LOGIC; use_bw = 1'b1; bw_sel = BW_AND; end
         OP_NOT:  begin we_d = 1'b1; use_bw = 1'b1; bw_sel = BW_NOT; end
         default: ;
      endcase
   end

   // full-width adder
   logic [DATA_W-1:0] wd_res;
   logic              wd_c, wd_a, wd_o;

   alu_addsub #(.W(DATA_W)) u_add_word (
      .x(ad_x), .y(ad_y), .cin(ad_cin), .sub(ad_sub),
      .res(wd_res), .cout(wd_c), .aux(wd_a), .ovf(wd_o)
   );

   // optional byte-width adder
   logic [BYTE_W-1:0] nr_res;
   logic              nr_c, nr_o;

   if (NARROW_EN) begin : g_narrow
      logic nr_a_unused;
      alu_addsub #(.W(BYTE_W)) u_add_byte (
         .x(ad_x[BYTE_W-1:0]), .y(ad_y[BYTE_W-1:0]), .cin(ad_cin), .sub(ad_sub),
         .res(nr_res), .cout(nr_c), .aux(nr_a_unused), .ovf(nr_o)
      );
      assign wide_eff = wide;
   end else begin : g_word_only
      assign nr_res   = '0;
      assign nr_c     = 1'b0;
      assign nr_o     = 1'b0;
      assign wide_eff = 1'b1;
   end

   logic [DATA_W-1:0] bw_res;

   alu_bitwise #(.W(DATA_W)) u_bitwise (
      .a(op_a), .b(op_b), .sel(bw_sel), .y(bw_res)
   );

   // result assembly: byte mode keeps operand A's upper byte
   logic [DATA_W-1:0] ar_out, bw_out;
   logic              c_sel, o_sel;

   always_comb begin
      ar_out = wide_eff ? wd_res : {op_a[DATA_W-1 -: HI_W], nr_res};
      bw_out = wide_eff ? bw_res : {op_a[DATA_W-1 -: HI_W], bw_res[BYTE_W-1:0]};
      result = use_bw ? bw_out : ar_out;
      c_sel  = wide_eff ? wd_c : nr_c;
      o_sel  = wide_eff ? wd_o : nr_o;
   end

   assign result_we = we_d;

   alu_flag_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .FLAG_W(FLAG_W)) u_merge (
      .res(result), .wide(wide_eff), .c_new(c_sel), .a_new(wd_a), .o_new(o_sel),
      .kind(kind), .flags_in(flags_in), .flags_out(flags_out)
   );

   // port-level checks
   logic a_nz;
   logic res_zero;
   assign a_nz     = wide_eff ? (op_a != '0) : (op_a[BYTE_W-1:0] != '0);
   assign res_zero = wide_eff ? (result == '0) : (result[BYTE_W-1:0] == '0);

   always_comb begin
      if (op == OP_CMP || op == OP_TEST) begin
         p_cmp_test_nowb_r3: assert (!result_we)
            else $error("compare/test requested a write");
      end
      if (op == OP_INC || op == OP_DEC) begin
         p_incdec_keepc_r4: assert (flags_out[FB_C] == flags_in[FB_C])
            else $error("inc/dec altered carry");
      end
      if (op == OP_NEG) begin
         p_neg_carry_r5: assert (flags_out[FB_C] == a_nz)
            else $error("negate carry does not track nonzero operand");
      end
      if (kind == FK_ARITH || kind == FK_KEEPC) begin
         p_zero_match_r1: assert (flags_out[FB_Z] == res_zero)
            else $error("zero flag disagrees with result");
      end
   end

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;

   logic        clk = 1'b0;
   logic [15:0] op_a, op_b, flags_in;
   logic [3:0]  op_code;
   logic        wide;
   logic [15:0] result, flags_out;
   logic        result_we;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [15:0] OTH  = 16'h9522;   // non-status bits
   localparam logic [15:0] STAT = 16'h08D5;   // all six status bits

   always #10 clk = ~clk;   // 50 MHz

   alu_flag_unit dut_i (
      .op_a(op_a), .op_b(op_b), .op_code(op_code), .wide(wide),
      .flags_in(flags_in), .result(result), .result_we(result_we),
      .flags_out(flags_out)
   );

   function automatic logic [15:0] mk(logic [15:0] fin, logic o, logic s, logic z,
                                      logic a, logic p, logic c);
      logic [15:0] r;
      r = fin & ~STAT;
      r[11] = o; r[7] = s; r[6] = z; r[4] = a; r[2] = p; r[0] = c;
      return r;
   endfunction

   task automatic apply(logic [3:0] code, logic [15:0] a, logic [15:0] b,
                        logic w, logic [15:0] fin);
      @(posedge clk);
      op_code = code; op_a = a; op_b = b; wide = w; flags_in = fin;
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [15:0] er, logic ew, logic [15:0] ef, bit use_res);
      n_cmp++;
      if ((use_res && result !== er) || result_we !== ew || flags_out !== ef) begin
         n_bad++;
         $display("FAIL %s: result %h exp %h, we %b exp %b, flags %h exp %h",
                  tag, result, er, result_we, ew, flags_out, ef);
      end
   endtask

   task automatic t_add;
      apply(4'd0, 16'h7FFF, 16'h0001, 1'b1, OTH);
      chk("R1 add overflow, R10 aux carry", 16'h8000, 1'b1, mk(OTH,1,1,0,1,1,0), 1);
      apply(4'd1, 16'hFFFF, 16'h0000, 1'b1, OTH | 16'h0001);
      chk("R1 adc carry-in wraps to zero", 16'h0000, 1'b1, mk(OTH,0,0,1,1,1,1), 1);
      apply(4'd0, 16'h0100, 16'h0000, 1'b1, OTH | STAT);
      chk("R9 parity from low byte only", 16'h0100, 1'b1, mk(OTH,0,0,0,0,1,0), 1);
   endtask

   task automatic t_sub;
      apply(4'd2, 16'h0000, 16'h0001, 1'b1, OTH);
      chk("R2 sub borrow, R10 aux borrow", 16'hFFFF, 1'b1, mk(OTH,0,1,0,1,1,1), 1);
      apply(4'd3, 16'h8000, 16'h0000, 1'b1, OTH | 16'h0001);
      chk("R2 sbb overflow", 16'h7FFF, 1'b1, mk(OTH,1,0,0,1,1,0), 1);
   endtask

   task automatic t_nowrite;
      apply(4'd4, 16'h1234, 16'h1234, 1'b1, OTH | STAT);
      chk("R3 cmp equal no write", 16'h0000, 1'b0, mk(OTH,0,0,1,0,1,0), 1);
      apply(4'd11, 16'h00F0, 16'h0F30, 1'b1, OTH | STAT);
      chk("R3 test no write, R6 clears", 16'h0030, 1'b0, mk(OTH,0,0,0,0,1,0), 1);
   endtask

   task automatic t_incdec;
      apply(4'd5, 16'h7FFF, 16'h0000, 1'b1, OTH | 16'h0001);
      chk("R4 inc keeps C=1", 16'h8000, 1'b1, mk(OTH,1,1,0,1,1,1), 1);
      apply(4'd6, 16'h0000, 16'h0000, 1'b1, OTH);
      chk("R4 dec keeps C=0", 16'hFFFF, 1'b1, mk(OTH,0,1,0,1,1,0), 1);
   endtask

   task automatic t_neg;
      apply(4'd7, 16'h0005, 16'h0000, 1'b1, OTH);
      chk("R5 neg nonzero", 16'hFFFB, 1'b1, mk(OTH,0,1,0,1,0,1), 1);
      apply(4'd7, 16'h0000, 16'h0000, 1'b1, OTH | STAT);
      chk("R5 neg zero clears C", 16'h0000, 1'b1, mk(OTH,0,0,1,0,1,0), 1);
      apply(4'd7, 16'h8000, 16'h0000, 1'b1, OTH);
      chk("R5 neg most negative", 16'h8000, 1'b1, mk(OTH,1,1,0,0,1,1), 1);
   endtask

   task automatic t_logic;
      apply(4'd8, 16'hFF0F, 16'h0F0F, 1'b1, OTH | STAT);
      chk("R6 and", 16'h0F0F, 1'b1, mk(OTH,0,0,0,0,1,0), 1);
      apply(4'd9, 16'h8000, 16'h0001, 1'b1, OTH | STAT);
      chk("R6 or sign, R9 odd parity", 16'h8001, 1'b1, mk(OTH,0,1,0,0,0,0), 1);
      apply(4'd10, 16'h5A5A, 16'h5A5A, 1'b1, OTH | STAT);
      chk("R6 xor zero", 16'h0000, 1'b1, mk(OTH,0,0,1,0,1,0), 1);
      apply(4'd12, 16'h00FF, 16'h1234, 1'b1, OTH | STAT);
      chk("R7 not keeps flags", 16'hFF00, 1'b1, OTH | STAT, 1);
   endtask

   task automatic t_byte;
      apply(4'd0, 16'h12FF, 16'h3401, 1'b0, OTH);
      chk("R12 byte add carry", 16'h1200, 1'b1, mk(OTH,0,0,1,1,1,1), 1);
      apply(4'd2, 16'hAB80, 16'h0001, 1'b0, OTH | 16'h0001);
      chk("R12 byte sub overflow", 16'hAB7F, 1'b1, mk(OTH,1,0,0,1,0,0), 1);
      apply(4'd12, 16'h3C0F, 16'h0000, 1'b0, OTH);
      chk("R12 byte not", 16'h3CF0, 1'b1, OTH, 1);
   endtask

   task automatic t_unused;
      apply(4'd13, 16'h1111, 16'h2222, 1'b1, OTH | 16'h0045);
      chk("R13 unused code 13", 16'h0000, 1'b0, OTH | 16'h0045, 0);
      apply(4'd15, 16'hFFFF, 16'hFFFF, 1'b0, OTH | 16'h0880);
      chk("R13 unused code 15, R11 passthrough", 16'h0000, 1'b0, OTH | 16'h0880, 0);
   endtask

   // R8 positions are carried by mk(); R11 by OTH in every expected word
   initial begin
      op_a = '0; op_b = '0; op_code = 4'd15; wide = 1'b1; flags_in = OTH;
      @(negedge clk);
      chk("R13 idle state", 16'h0000, 1'b0, OTH, 0);
      t_add();
      t_sub();
      t_nowrite();
      t_incdec();
      t_neg();
      t_logic();
      t_byte();
      t_unused();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung, expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule